// File: doc/BRIEF.md
# Synchronous Shift-Register Serial Port

This block is the half-duplex shift-register mode of a small serial port. It moves one 8-bit frame at a time over a single shared data pin and drives a shift clock on a second pin. The host writes a byte into the buffer register to send it. To receive a frame, the host holds the receive enable high and clears the receive flag. Both directions send the least significant bit first. Every bit cell lasts a fixed number of oscillator periods. The shift clock rests high and drops low partway through each cell. It rises near the end of the cell, and that rise is the point where an external shift register latches transmitted data and where the port samples received data.

At the end of a frame the port raises a transmit-complete or a receive-complete flag. Each flag stays set until the host clears it with a strobe. The data pin is driven only while a byte is being sent. A buffer write or a receive trigger that arrives while a frame is running is dropped. One clock cycle of the block is one oscillator period.

Top module: `ssp_sync_port`

## Requirements
- R1: A bit cell is 12 clock cycles long, with phases 0 to 11. During a frame the shift clock `sclk_o` is low in phases 4 to 9 and high in phases 0 to 3 and 10 to 11. Its rising edge therefore falls between phase 9 and phase 10.
- R2: A frame holds exactly 8 bit cells. Bit 0 (the LSB) goes in the first cell and bit 7 in the last.
- R3: On transmit, `sdat_o` changes only at the start of a cell and keeps the bit value for all 12 phases. Data is thus valid 10 cycles before the shift-clock rise and 2 cycles after it.
- R4: On receive, `sdat_i` is sampled at the clock edge that ends phase 9, which is the edge where `sclk_o` rises.
- R5: A `buf_wr` pulse while the port is idle loads `buf_wdata` and starts a transmit frame. `ti` reads 1 starting 96 cycles after the starting edge. It stays 1 until a `ti_clr` pulse, which clears it on the next edge.
- R6: A `ri_clr` pulse while the port is idle and `rx_enable` is 1 clears `ri` and starts a receive frame. 96 cycles after the starting edge, `ri` reads 1 and `buf_rdata` holds the received byte, first-received bit in bit 0.
- R7: A `buf_wr` or `ri_clr` that arrives during an active frame is ignored: the frame keeps its data and ends on time.
- R8: `sdat_oe` is 1 only during a transmit frame. It is 0 while idle and during reception.
- R9: After reset `sclk_o`=1, `sdat_oe`=0, `ti`=0, `ri`=0 and `buf_rdata`=0.
- R10: A `ri_clr` pulse with `rx_enable` low starts no frame, and `sclk_o` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock, one cycle per oscillator period |
| rst_n | input | 1 | Active-low synchronous reset |
| buf_wr | input | 1 | Buffer write strobe, starts a transmit frame |
| buf_wdata | input | 8 | Byte to send |
| buf_rdata | output | 8 | Last byte received |
| rx_enable | input | 1 | Receive enable level |
| ti_clr | input | 1 | Clears the transmit-complete flag |
| ri_clr | input | 1 | Clears the receive-complete flag, starts reception |
| ti | output | 1 | Transmit-complete flag |
| ri | output | 1 | Receive-complete flag |
| sclk_o | output | 1 | Shift clock, idles high |
| sdat_o | output | 1 | Serial data out |
| sdat_oe | output | 1 | Output enable for the shared data pin |
| sdat_i | input | 1 | Serial data in |

## Verification
Take the edge that samples a start strobe as edge 0. Cell b, phase p is then visible in the cycle after edge 12b+p, and both flags become visible after edge 96. The bench drives strobes at falling edges and samples at every falling edge that follows. For each of the 96 cycles of a frame it compares the shift clock, the enable and the data bit against values it computes from the cycle index. It checks the flags exactly one falling edge after the 96th cycle, and also in the cycle just before that. Received bits are driven with the correct value only during phase 9 and with the inverted value elsewhere. A sampling point off by even one cycle therefore corrupts the byte.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  typedef enum logic [1:0] {MODE_IDLE = 2'd0, MODE_TX = 2'd1, MODE_RX = 2'd2} ssp_mode_e;

  // Shift clock level for a given phase of an active cell.
  function automatic logic clk_level(input int phase, input int low_at, input int rise_at,
                                     input logic active);
    if (!active) return 1'b1;
    return !((phase >= low_at) && (phase < rise_at));
  endfunction

  // Total cycles per frame.
  function automatic int frame_cycles(input int cell_len, input int nbits);
    return cell_len * nbits;
  endfunction
endpackage

// File: rtl/ssp_seq.sv
module ssp_seq
  import ssp_pkg::*;
#(
  parameter int CELL_LEN = 12,
  parameter int NBITS    = 8,
  parameter int RISE_AT  = 10,
  localparam int PW = $clog2(CELL_LEN),
  localparam int BW = $clog2(NBITS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_tx,
  input  logic          start_rx,
  output ssp_mode_e     mode,
  output logic [PW-1:0] phase,
  output logic          sample_now,
  output logic          cell_end,
  output logic          frame_end
);
  ssp_mode_e     mode_q;
  logic [PW-1:0] phase_q;
  logic [BW-1:0] bit_q;
  logic          active;

  assign active     = (mode_q != MODE_IDLE);
  assign sample_now = active && (phase_q == PW'(RISE_AT - 1));
  assign cell_end   = active && (phase_q == PW'(CELL_LEN - 1));
  assign frame_end  = cell_end && (bit_q == BW'(NBITS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= MODE_IDLE;
      phase_q <= '0;
      bit_q   <= '0;
    end else if (start_tx) begin
      mode_q  <= MODE_TX;
      phase_q <= '0;
      bit_q   <= '0;
    end else if (start_rx) begin
      mode_q  <= MODE_RX;
      phase_q <= '0;
      bit_q   <= '0;
    end else if (active) begin
      if (cell_end) begin
        phase_q <= '0;
        if (frame_end) mode_q <= MODE_IDLE;
        else           bit_q  <= bit_q + 1'b1;
      end else begin
        phase_q <= phase_q + 1'b1;
      end
    end
  end

  assign mode  = mode_q;
  assign phase = phase_q;
endmodule

// File: rtl/ssp_shifter.sv
module ssp_shifter #(
  parameter int NBITS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [NBITS-1:0] load_data,
  input  logic             shift_out,
  input  logic             shift_in,
  input  logic             sdi,
  output logic [NBITS-1:0] sreg
);
  logic [NBITS-1:0] sreg_q;

  always_ff @(posedge clk) begin
    if (!rst_n)         sreg_q <= '0;
    else if (load)      sreg_q <= load_data;
    else if (shift_in)  sreg_q <= {sdi, sreg_q[NBITS-1:1]};
    else if (shift_out) sreg_q <= {1'b1, sreg_q[NBITS-1:1]};
  end

  assign sreg = sreg_q;
endmodule

// File: rtl/ssp_flags.sv
module ssp_flags #(
  parameter int NBITS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_done,
  input  logic             rx_done,
  input  logic             ti_clr,
  input  logic             ri_clr_ok,
  input  logic [NBITS-1:0] rx_byte,
  output logic             ti,
  output logic             ri,
  output logic [NBITS-1:0] rdata
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ti    <= 1'b0;
      ri    <= 1'b0;
      rdata <= '0;
    end else begin
      if (tx_done)     ti <= 1'b1;
      else if (ti_clr) ti <= 1'b0;
      if (rx_done) begin
        ri    <= 1'b1;
        rdata <= rx_byte;
      end else if (ri_clr_ok) begin
        ri <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ssp_sync_port.sv
module ssp_sync_port
  import ssp_pkg::*;
#(
  parameter int CELL_LEN = 12,
  parameter int NBITS    = 8,
  parameter int LOW_AT   = 4,
  parameter int RISE_AT  = 10,
  localparam int PW = $clog2(CELL_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             buf_wr,
  input  logic [NBITS-1:0] buf_wdata,
  output logic [NBITS-1:0] buf_rdata,
  input  logic             rx_enable,
  input  logic             ti_clr,
  input  logic             ri_clr,
  output logic             ti,
  output logic             ri,
  output logic             sclk_o,
  output logic             sdat_o,
  output logic             sdat_oe,
  input  logic             sdat_i
);
  ssp_mode_e        mode;
  logic [PW-1:0]    phase;
  logic             sample_now, cell_end, frame_end;
  logic             busy, tx_act, rx_act;
  logic             start_tx, start_rx, start_evt;
  logic [NBITS-1:0] sreg;

  assign busy      = (mode != MODE_IDLE);
  assign tx_act    = (mode == MODE_TX);
  assign rx_act    = (mode == MODE_RX);
  assign start_tx  = buf_wr && !busy;
  assign start_rx  = ri_clr && rx_enable && !busy && !buf_wr;
  assign start_evt = start_tx || start_rx;

  ssp_seq #(.CELL_LEN(CELL_LEN), .NBITS(NBITS), .RISE_AT(RISE_AT)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_tx(start_tx), .start_rx(start_rx),
    .mode(mode), .phase(phase), .sample_now(sample_now),
    .cell_end(cell_end), .frame_end(frame_end)
  );

  ssp_shifter #(.NBITS(NBITS)) u_sh (
    .clk(clk), .rst_n(rst_n), .load(start_tx), .load_data(buf_wdata),
    .shift_out(tx_act && cell_end), .shift_in(rx_act && sample_now),
    .sdi(sdat_i), .sreg(sreg)
  );

  ssp_flags #(.NBITS(NBITS)) u_flg (
    .clk(clk), .rst_n(rst_n),
    .tx_done(tx_act && frame_end), .rx_done(rx_act && frame_end),
    .ti_clr(ti_clr), .ri_clr_ok(start_rx), .rx_byte(sreg),
    .ti(ti), .ri(ri), .rdata(buf_rdata)
  );

  assign sclk_o  = clk_level(int'(phase), LOW_AT, RISE_AT, busy);
  assign sdat_oe = tx_act;
  assign sdat_o  = tx_act ? sreg[0] : 1'b1;
endmodule

// File: rtl/ssp_sync_port_chk.sv
module ssp_sync_port_chk #(
  parameter int CELL_LEN = 12,
  parameter int NBITS    = 8
) (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic tx_act,
  input logic rx_act,
  input logic start_evt,
  input logic frame_end,
  input logic sclk_o,
  input logic sdat_o,
  input logic sdat_oe,
  input logic ti,
  input logic ri
);
  localparam int FRAME = CELL_LEN * NBITS;
  int   cyc_cnt;
  int   rise_cnt;
  logic sclk_q;
  logic rise;

  assign rise = sclk_o && !sclk_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cyc_cnt  <= 0;
      rise_cnt <= 0;
      sclk_q   <= 1'b1;
    end else begin
      sclk_q <= sclk_o;
      if (start_evt) begin
        cyc_cnt  <= 0;
        rise_cnt <= 0;
      end else begin
        if (busy) cyc_cnt <= cyc_cnt + 1;
        if (rise) rise_cnt <= rise_cnt + 1;
      end
    end
  end

  assert_frame_len_R1: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |-> cyc_cnt == FRAME - 1);
  assert_idle_clk_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sclk_o);
  assert_eight_rises_R2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |-> rise_cnt == NBITS);
  assert_data_hold_at_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_act && rise) |-> $stable(sdat_o));
  assert_ti_from_tx_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ti) |-> $past(tx_act && frame_end));
  assert_ri_from_rx_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ri) |-> $past(rx_act && frame_end));
  assert_oe_only_tx_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sdat_oe |-> (tx_act && !rx_act));
endmodule

bind ssp_sync_port ssp_sync_port_chk #(.CELL_LEN(CELL_LEN), .NBITS(NBITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .tx_act(tx_act), .rx_act(rx_act),
  .start_evt(start_evt), .frame_end(frame_end), .sclk_o(sclk_o), .sdat_o(sdat_o),
  .sdat_oe(sdat_oe), .ti(ti), .ri(ri)
);

// File: tb/sim_ssp_sync_port.sv
module sim_ssp_sync_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       buf_wr = 1'b0;
  logic [7:0] buf_wdata = 8'h00;
  logic [7:0] buf_rdata;
  logic       rx_enable = 1'b0;
  logic       ti_clr = 1'b0;
  logic       ri_clr = 1'b0;
  logic       ti, ri, sclk_o, sdat_o, sdat_oe;
  logic       sdat_i = 1'b1;
  int         checks = 0;
  int         errors = 0;
  bit         done = 0;

  always #10 clk = ~clk;

  ssp_sync_port u0 (
    .clk(clk), .rst_n(rst_n), .buf_wr(buf_wr), .buf_wdata(buf_wdata),
    .buf_rdata(buf_rdata), .rx_enable(rx_enable), .ti_clr(ti_clr), .ri_clr(ri_clr),
    .ti(ti), .ri(ri), .sclk_o(sclk_o), .sdat_o(sdat_o), .sdat_oe(sdat_oe), .sdat_i(sdat_i)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic exp_sclk(input int i);
    int p = i % 12;
    return !(p >= 4 && p <= 9);
  endfunction

  // Transmit one byte; optional mid-frame write of another value.
  task automatic t_send(input logic [7:0] b, input bit poke, input string req);
    int bad_clk = 0, bad_dat = 0, bad_oe = 0;
    @(negedge clk); buf_wr = 1'b1; buf_wdata = b;
    @(negedge clk); buf_wr = 1'b0;
    for (int i = 0; i < 96; i++) begin
      if (sclk_o !== exp_sclk(i)) bad_clk++;
      if (sdat_o !== b[i/12])     bad_dat++;
      if (sdat_oe !== 1'b1)       bad_oe++;
      if (i == 95) chk(ti === 1'b0, {req, " R5 ti early"}, ti, 0);
      if (poke && i == 30) begin buf_wr = 1'b1; buf_wdata = ~b; end
      else buf_wr = 1'b0;
      @(negedge clk);
    end
    chk(bad_clk == 0, {req, " R1 sclk pattern"}, bad_clk, 0);
    chk(bad_dat == 0, {req, " R2 R3 data bits"}, bad_dat, 0);
    chk(bad_oe == 0, {req, " R8 oe in tx"}, bad_oe, 0);
    chk(ti === 1'b1, {req, " R5 ti set"}, ti, 1);
    chk(sdat_oe === 1'b0 && sclk_o === 1'b1, {req, " R8 idle after"}, {sdat_oe, sclk_o}, 1);
    ti_clr = 1'b1; @(negedge clk); ti_clr = 1'b0;
    chk(ti === 1'b0, {req, " R5 ti clear"}, ti, 0);
  endtask

  // Receive one byte; data correct only in phase 9 of each cell.
  task automatic t_recv(input logic [7:0] b, input bit poke, input string req);
    int bad_clk = 0, bad_oe = 0;
    rx_enable = 1'b1;
    @(negedge clk); ri_clr = 1'b1;
    @(negedge clk); ri_clr = 1'b0;
    chk(ri === 1'b0, {req, " R6 ri cleared"}, ri, 0);
    for (int i = 0; i < 96; i++) begin
      sdat_i = ((i % 12) == 9) ? b[i/12] : ~b[i/12];
      if (sclk_o !== exp_sclk(i)) bad_clk++;
      if (sdat_oe !== 1'b0)       bad_oe++;
      if (poke && i == 40) buf_wr = 1'b1; else buf_wr = 1'b0;
      if (poke && i == 50) ri_clr = 1'b1; else ri_clr = 1'b0;
      @(negedge clk);
    end
    chk(bad_clk == 0, {req, " R1 R7 rx sclk"}, bad_clk, 0);
    chk(bad_oe == 0, {req, " R8 oe low in rx"}, bad_oe, 0);
    chk(ri === 1'b1, {req, " R6 ri set"}, ri, 1);
    chk(buf_rdata === b, {req, " R4 R6 rx byte"}, buf_rdata, b);
    rx_enable = 1'b0;
  endtask

  task automatic t_reset();
    chk(sclk_o === 1'b1 && sdat_oe === 1'b0, "R9 pins", {sclk_o, sdat_oe}, 2);
    chk(ti === 1'b0 && ri === 1'b0 && buf_rdata === 8'h00, "R9 flags", {ti, ri, buf_rdata}, 0);
  endtask

  task automatic t_rx_disabled();
    int moved = 0;
    rx_enable = 1'b0;
    @(negedge clk); ri_clr = 1'b1;
    @(negedge clk); ri_clr = 1'b0;
    for (int i = 0; i < 30; i++) begin
      if (sclk_o !== 1'b1 || sdat_oe !== 1'b0) moved++;
      @(negedge clk);
    end
    chk(moved == 0, "R10 no rx start", moved, 0);
    chk(ri === 1'b1, "R10 ri untouched", ri, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_send(8'hA5, 1'b0, "tx A5");
    t_send(8'h01, 1'b0, "tx 01");
    t_send(8'h80, 1'b1, "tx 80 R7");
    t_recv(8'h3C, 1'b0, "rx 3C");
    t_recv(8'hC3, 1'b1, "rx C3 R7");
    t_rx_disabled();
    done = 1;
  end

  initial begin
    int n = 0;
    while (!done && n < 20000) begin
      @(posedge clk);
      n++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", n, 0);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule